// File: doc/BRIEF.md
# Fuse Array Word-Read Sequencer

This controller copies a contiguous range of a one-time-programmable fuse array into a byte buffer. The host gives a start address, a byte count and a one-cycle start pulse. The controller then brings the fuse macro out of isolation through a fixed, ordered power sequence. It reads the range one 32-bit word at a time and writes every word into the buffer as four bytes, low byte first. Last, it returns the macro to its isolated, unpowered state and pulses `done`.

The fuse macro is driven as a small register-style target. Each request is a one-cycle pulse that carries the word address and clears the macro's ready flag. The macro raises ready when the data word is valid. If ready does not come, a cycle counter stops the wait, and the power-down sequence still runs before the error is reported. The settle delay between the two power switches and the ready timeout are cycle counts derived from the clock frequency. An input selects a silicon revision that skips the isolation and power-switch steps.

Top module: `fuse_word_reader`

## Requirements
- R1: A start whose address or byte count has either of bits [1:0] set is rejected. `done` pulses on the next cycle with `err_align` high, and no power-control output, request or buffer write changes.
- R2: An aligned start with a byte count of zero pulses `done` on the next cycle with both error flags low and no power sequence.
- R3: Power-up happens in this order, each step on its own cycle: `wmask_dis` rises, then `pwr_sw_a` rises, then `pwr_sw_b` rises at least SETTLE cycles later (SETTLE = CLK_KHZ*SETTLE_US/1000), then `iso_en` falls, then `burst_en` rises. All of this comes before the first fuse request.
- R4: Power-down happens in this order: `iso_en` rises, then `pwr_sw_b` falls, then `pwr_sw_a` falls at least SETTLE cycles later, then `wmask_dis` falls, then `burst_en` falls. At the `done` pulse all five power outputs are back at their reset values.
- R5: When `skip_pwr_sw` is high at start, `pwr_sw_a`, `pwr_sw_b` and `iso_en` never change during the run. `wmask_dis` still rises before `burst_en` rises, and falls before `burst_en` falls.
- R6: Each word is requested by a one-cycle `fz_req` pulse with `fz_addr` valid. `fz_rdy` is not sampled in the cycle in which the request is visible, so a stale ready from the previous word is never taken.
- R7: If `fz_rdy` has not been seen TIMEOUT cycles (CLK_KHZ*TIMEOUT_MS) after a request, the run stops reading and performs the full power-down. It then pulses `done` with `err_timeout` high and has made no buffer write for that word.
- R8: After ready, the 32-bit `fz_data` is written to the buffer as four single-byte writes on consecutive cycles, bits [7:0] first. Buffer offsets count from 0 at the start of each run, so a run of N bytes writes offsets 0 to N-1 exactly once.
- R9: Request addresses start at `start_addr` and grow by 4 per word, and a successful run issues exactly `byte_size`/4 requests.
- R10: `done` is high for exactly one cycle per accepted start. A start pulse while `busy` is high is ignored.
- R11: In reset, or after a reset taken in the middle of a run, `busy`, `done`, `fz_req`, `buf_we`, `wmask_dis`, `pwr_sw_a`, `pwr_sw_b` and `burst_en` are low and `iso_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse |
| start_addr | input | ADDR_W | First fuse byte address |
| byte_size | input | SIZE_W | Number of bytes to copy |
| skip_pwr_sw | input | 1 | Skip isolation and power-switch steps |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_align | output | 1 | Last request was misaligned |
| err_timeout | output | 1 | Last run timed out waiting for ready |
| wmask_dis | output | 1 | Write-mask disable control |
| pwr_sw_a | output | 1 | First fuse power switch |
| pwr_sw_b | output | 1 | Second fuse power switch |
| iso_en | output | 1 | Isolation between fuse macro and core |
| burst_en | output | 1 | Fuse burst-mode enable |
| fz_req | output | 1 | Read request pulse, clears macro ready |
| fz_addr | output | ADDR_W | Word address of the request |
| fz_rdy | input | 1 | Macro ready flag |
| fz_data | input | 32 | Macro data word |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | SIZE_W | Buffer byte offset |
| buf_data | output | 8 | Buffer byte value |

## Verification
The assertions assume that `fz_rdy` may stay high from a previous word until the macro has seen the next request. They also assume that `start` fields are stable only in the cycle of the pulse. The bench's macro model keeps the old ready high for one extra cycle after a request in some runs, and never raises it in another. It drives the start fields for a single cycle, and in one run it pulses `start` again while the block is busy. The latencies it uses stay below the timeout, except in the run that is meant to expire.

// File: rtl/fuse_word_reader.sv
module fuse_word_reader #(
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned SETTLE_US  = 1000,
  parameter int unsigned TIMEOUT_MS = 1000,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned SIZE_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [SIZE_W-1:0] byte_size,
  input  logic              skip_pwr_sw,
  output logic              busy,
  output logic              done,
  output logic              err_align,
  output logic              err_timeout,
  output logic              wmask_dis,
  output logic              pwr_sw_a,
  output logic              pwr_sw_b,
  output logic              iso_en,
  output logic              burst_en,
  output logic              fz_req,
  output logic [ADDR_W-1:0] fz_addr,
  input  logic              fz_rdy,
  input  logic [31:0]       fz_data,
  output logic              buf_we,
  output logic [SIZE_W-1:0] buf_addr,
  output logic [7:0]        buf_data
);

  localparam int unsigned SETTLE_CYC = CLK_KHZ * SETTLE_US / 1000;
  localparam int unsigned TO_CYC     = CLK_KHZ * TIMEOUT_MS;
  localparam int unsigned LIM_CYC    = (SETTLE_CYC > TO_CYC) ? SETTLE_CYC : TO_CYC;
  localparam int unsigned CNT_W      = $clog2(LIM_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LAST     = CNT_W'(TO_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_UP_WM, S_UP_SWA, S_UP_WAIT, S_UP_SWB, S_UP_ISO, S_UP_BURST,
    S_REQ, S_POLL, S_STORE,
    S_DN_ISO, S_DN_SWB, S_DN_WAIT, S_DN_SWA, S_DN_WM, S_DN_BURST
  } st_t;

  st_t               st;
  logic              skip_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [SIZE_W-1:0] left;
  logic [SIZE_W-1:0] bptr;
  logic [31:0]       word;
  logic [1:0]        bsel;
  logic [CNT_W-1:0]  cnt;

  wire  misaligned = (|start_addr[1:0]) | (|byte_size[1:0]);
  wire  last_word  = (left == SIZE_W'(4));
  wire  [31:0] word_sh = word >> {bsel, 3'b000};
  wire  st_t dn_first = skip_q ? S_DN_WM : S_DN_ISO;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      skip_q      <= 1'b0;
      cur_addr    <= '0;
      left        <= '0;
      bptr        <= '0;
      word        <= '0;
      bsel        <= '0;
      cnt         <= '0;
      done        <= 1'b0;
      err_align   <= 1'b0;
      err_timeout <= 1'b0;
      wmask_dis   <= 1'b0;
      pwr_sw_a    <= 1'b0;
      pwr_sw_b    <= 1'b0;
      iso_en      <= 1'b1;
      burst_en    <= 1'b0;
      fz_req      <= 1'b0;
      fz_addr     <= '0;
      buf_we      <= 1'b0;
      buf_addr    <= '0;
      buf_data    <= '0;
    end else begin
      done   <= 1'b0;
      buf_we <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          err_align   <= misaligned;
          err_timeout <= 1'b0;
          skip_q      <= skip_pwr_sw;
          cur_addr    <= start_addr;
          left        <= byte_size;
          bptr        <= '0;
          if (misaligned || byte_size == '0) done <= 1'b1;
          else st <= S_UP_WM;
        end
        S_UP_WM: begin
          wmask_dis <= 1'b1;
          st <= skip_q ? S_UP_BURST : S_UP_SWA;
        end
        S_UP_SWA: begin
          pwr_sw_a <= 1'b1;
          cnt <= '0;
          st <= S_UP_WAIT;
        end
        S_UP_WAIT: begin
          if (cnt == SETTLE_LAST) st <= S_UP_SWB;
          else cnt <= cnt + 1'b1;
        end
        S_UP_SWB: begin
          pwr_sw_b <= 1'b1;
          st <= S_UP_ISO;
        end
        S_UP_ISO: begin
          iso_en <= 1'b0;
          st <= S_UP_BURST;
        end
        S_UP_BURST: begin
          burst_en <= 1'b1;
          st <= S_REQ;
        end
        S_REQ: begin
          fz_req  <= 1'b1;
          fz_addr <= cur_addr;
          cnt     <= '0;
          st      <= S_POLL;
        end
        S_POLL: begin
          fz_req <= 1'b0;
          if (!fz_req) begin
            if (fz_rdy) begin
              word <= fz_data;
              bsel <= '0;
              st   <= S_STORE;
            end else if (cnt == TO_LAST) begin
              err_timeout <= 1'b1;
              st <= dn_first;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_STORE: begin
          buf_we   <= 1'b1;
          buf_addr <= bptr;
          buf_data <= word_sh[7:0];
          bptr     <= bptr + 1'b1;
          bsel     <= bsel + 1'b1;
          if (bsel == 2'd3) begin
            cur_addr <= cur_addr + ADDR_W'(4);
            left     <= left - SIZE_W'(4);
            st       <= last_word ? dn_first : S_REQ;
          end
        end
        S_DN_ISO: begin
          iso_en <= 1'b1;
          st <= S_DN_SWB;
        end
        S_DN_SWB: begin
          pwr_sw_b <= 1'b0;
          cnt <= '0;
          st <= S_DN_WAIT;
        end
        S_DN_WAIT: begin
          if (cnt == SETTLE_LAST) st <= S_DN_SWA;
          else cnt <= cnt + 1'b1;
        end
        S_DN_SWA: begin
          pwr_sw_a <= 1'b0;
          st <= S_DN_WM;
        end
        S_DN_WM: begin
          wmask_dis <= 1'b0;
          st <= S_DN_BURST;
        end
        S_DN_BURST: begin
          burst_en <= 1'b0;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && misaligned) |=> (done && err_align && !wmask_dis && !fz_req));

  a_r2_zero_size: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !misaligned && byte_size == '0) |=> (done && !err_align && !wmask_dis));

  a_r3_swb_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_sw_b) |-> (pwr_sw_a && wmask_dis && iso_en));

  a_r3_iso_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (pwr_sw_b && !burst_en));

  a_r3_burst_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_en) |-> (wmask_dis && (skip_q ? iso_en : !iso_en)));

  a_r4_swa_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_sw_a) |-> (!pwr_sw_b && iso_en && wmask_dis));

  a_r4_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wmask_dis && !pwr_sw_a && !pwr_sw_b && iso_en && !burst_en));

  a_r5_skip_still: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && skip_q) |-> (!pwr_sw_a && !pwr_sw_b && iso_en));

  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fz_req |=> !fz_req);

  a_r6_req_powered: assert property (@(posedge clk) disable iff (!rst_n)
    fz_req |-> (burst_en && !buf_we));

  a_r8_write_powered: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (burst_en && wmask_dis));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/fuse_word_reader_tb.sv
module fuse_word_reader_tb;

  localparam int unsigned SETTLE = 10;
  localparam int unsigned TO     = 30;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] n;
    logic        skip;
    logic        stale;
    logic [7:0]  lat;
    logic        poke;
    logic        ealign;
    logic        eto;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [0:NV-1] = '{
    '{16'h0000, 16'd16, 1'b0, 1'b0, 8'd1,   1'b0, 1'b0, 1'b0},
    '{16'h0104, 16'd8,  1'b1, 1'b1, 8'd3,   1'b0, 1'b0, 1'b0},
    '{16'h0040, 16'd4,  1'b0, 1'b1, 8'd20,  1'b1, 1'b0, 1'b0},
    '{16'h0002, 16'd8,  1'b0, 1'b0, 8'd1,   1'b0, 1'b1, 1'b0},
    '{16'h0010, 16'd6,  1'b1, 1'b0, 8'd1,   1'b0, 1'b1, 1'b0},
    '{16'h0020, 16'd8,  1'b0, 1'b0, 8'd255, 1'b0, 1'b0, 1'b1},
    '{16'h0000, 16'd0,  1'b0, 1'b0, 8'd1,   1'b0, 1'b0, 1'b0},
    '{16'hFFF8, 16'd8,  1'b0, 1'b0, 8'd2,   1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [15:0] byte_size = '0;
  logic        skip_pwr_sw = 1'b0;
  logic        busy, done, err_align, err_timeout;
  logic        wmask_dis, pwr_sw_a, pwr_sw_b, iso_en, burst_en;
  logic        fz_req;
  logic [15:0] fz_addr;
  logic        fz_rdy = 1'b1;
  logic [31:0] fz_data = '0;
  logic        buf_we;
  logic [15:0] buf_addr;
  logic [7:0]  buf_data;

  fuse_word_reader #(.CLK_KHZ(10), .SETTLE_US(1000), .TIMEOUT_MS(3),
                     .ADDR_W(16), .SIZE_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_size(byte_size), .skip_pwr_sw(skip_pwr_sw), .busy(busy), .done(done),
    .err_align(err_align), .err_timeout(err_timeout), .wmask_dis(wmask_dis),
    .pwr_sw_a(pwr_sw_a), .pwr_sw_b(pwr_sw_b), .iso_en(iso_en), .burst_en(burst_en),
    .fz_req(fz_req), .fz_addr(fz_addr), .fz_rdy(fz_rdy), .fz_data(fz_data),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data));

  always #5 clk = ~clk;

  function automatic logic [31:0] fdata(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a + 16'h1357};
  endfunction

  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int          run_id = 0;
  int          seen_id = 0;
  logic [7:0]  cur_lat = 8'd1;
  logic        cur_stale = 1'b0;
  logic [15:0] cur_base = '0;
  int cyc = 0;
  int n_wm_r, n_swa_r, n_iso_f, n_req, n_we, n_done, addr_err, off_bad;
  int t_wm_r, t_swa_r, t_swb_r, t_iso_f, t_burst_r, t_req1;
  int t_iso_r, t_swb_f, t_swa_f, t_wm_f, t_burst_f, t_done;
  logic [15:0] exp_addr;
  logic [7:0]  mem [0:63];
  logic p_wm = 1'b0, p_swa = 1'b0, p_swb = 1'b0, p_iso = 1'b1, p_burst = 1'b0;
  logic        pend = 1'b0;
  int          lcnt = 0;
  logic [15:0] m_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (seen_id != run_id) begin
      seen_id = run_id;
      n_wm_r = 0; n_swa_r = 0; n_iso_f = 0; n_req = 0; n_we = 0; n_done = 0;
      addr_err = 0; off_bad = 0;
      t_wm_r = 0; t_swa_r = 0; t_swb_r = 0; t_iso_f = 0; t_burst_r = 0; t_req1 = 0;
      t_iso_r = 0; t_swb_f = 0; t_swa_f = 0; t_wm_f = 0; t_burst_f = 0; t_done = 0;
      exp_addr = cur_base;
      for (int i = 0; i < 64; i++) mem[i] = 8'hEE;
    end
    if (wmask_dis && !p_wm) begin n_wm_r++; t_wm_r = cyc; end
    if (!wmask_dis && p_wm) t_wm_f = cyc;
    if (pwr_sw_a && !p_swa) begin n_swa_r++; t_swa_r = cyc; end
    if (!pwr_sw_a && p_swa) t_swa_f = cyc;
    if (pwr_sw_b && !p_swb) t_swb_r = cyc;
    if (!pwr_sw_b && p_swb) t_swb_f = cyc;
    if (!iso_en && p_iso) begin n_iso_f++; t_iso_f = cyc; end
    if (iso_en && !p_iso) t_iso_r = cyc;
    if (burst_en && !p_burst) t_burst_r = cyc;
    if (!burst_en && p_burst) t_burst_f = cyc;
    p_wm = wmask_dis; p_swa = pwr_sw_a; p_swb = pwr_sw_b; p_iso = iso_en; p_burst = burst_en;
    if (done) begin
      n_done++; t_done = cyc;
      if (wmask_dis || pwr_sw_a || pwr_sw_b || !iso_en || burst_en) off_bad++;
    end
    if (buf_we) begin
      n_we++;
      if (buf_addr < 16'd64) mem[buf_addr[5:0]] = buf_data;
    end
    if (fz_req) begin
      n_req++;
      if (n_req == 1) t_req1 = cyc;
      if (fz_addr !== exp_addr) addr_err++;
      exp_addr = exp_addr + 16'd4;
      m_addr = fz_addr;
      if (cur_stale) pend = 1'b1;
      else begin fz_rdy = 1'b0; lcnt = int'(cur_lat); end
    end else if (pend) begin
      pend = 1'b0; fz_rdy = 1'b0; lcnt = int'(cur_lat);
    end else if (!fz_rdy && cur_lat != 8'd255) begin
      if (lcnt <= 1) begin fz_rdy = 1'b1; fz_data = fdata(m_addr); end
      else lcnt--;
    end
  end

  task automatic run(input vec_t v);
    bit seen;
    int bad;
    bit powered;
    cur_lat = v.lat; cur_stale = v.stale; cur_base = v.a;
    run_id++;
    @(negedge clk);
    start = 1'b1; start_addr = v.a; byte_size = v.n; skip_pwr_sw = v.skip;
    @(negedge clk);
    start = 1'b0; start_addr = 16'h0BAD; byte_size = 16'h0007; skip_pwr_sw = ~v.skip;
    seen = 1'b0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      if (v.poke && k == 5) begin
        start = 1'b1; start_addr = 16'h0200; byte_size = 16'd4;
      end else start = 1'b0;
      if (done) seen = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("watchdog R10 done seen", {31'd0, seen}, 32'd1);
    powered = !v.ealign && v.n != 0;
    chk("R1 err_align", {31'd0, err_align}, {31'd0, v.ealign});
    chk("R7 err_timeout", {31'd0, err_timeout}, {31'd0, v.eto});
    chk("R10 done pulse count", n_done, 1);
    chk("R1 R2 power-up count", n_wm_r, {31'd0, powered});
    chk("R5 switch rises", n_swa_r, {31'd0, powered && !v.skip});
    chk("R5 isolation drops", n_iso_f, {31'd0, powered && !v.skip});
    chk("R6 R9 request count", n_req, v.eto ? 1 : (powered ? int'(v.n) / 4 : 0));
    chk("R9 R10 request addresses", addr_err, 0);
    chk("R8 byte writes", n_we, (powered && !v.eto) ? int'(v.n) : 0);
    chk("R4 R7 off at done", off_bad, 0);
    if (powered && !v.eto) begin
      bad = 0;
      for (int i = 0; i < int'(v.n); i++) begin
        logic [31:0] w;
        w = fdata(v.a + 16'(4 * (i / 4))) >> (8 * (i % 4));
        if (mem[i] !== w[7:0]) bad++;
      end
      chk("R6 R8 buffer bytes", bad, 0);
    end
    if (powered && !v.skip) begin
      chk("R3 wm before swa", {31'd0, t_wm_r < t_swa_r}, 1);
      chk("R3 settle up", {31'd0, t_swb_r - t_swa_r >= int'(SETTLE)}, 1);
      chk("R3 swb iso burst req", {31'd0, t_swb_r < t_iso_f && t_iso_f < t_burst_r && t_burst_r < t_req1}, 1);
      chk("R4 iso before swb", {31'd0, t_iso_r < t_swb_f}, 1);
      chk("R4 settle down", {31'd0, t_swa_f - t_swb_f >= int'(SETTLE)}, 1);
      chk("R4 swa wm burst", {31'd0, t_swa_f < t_wm_f && t_wm_f < t_burst_f && t_burst_f <= t_done}, 1);
    end
    if (powered && v.skip) begin
      chk("R5 wm burst req", {31'd0, t_wm_r < t_burst_r && t_burst_r < t_req1}, 1);
      chk("R5 wm off before burst", {31'd0, t_wm_f < t_burst_f}, 1);
    end
    if (v.eto) chk("R7 timeout wait", {31'd0, t_done - t_req1 >= int'(TO)}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset busy", {31'd0, busy}, 0);
    chk("R11 reset done", {31'd0, done}, 0);
    chk("R11 reset power", {27'd0, wmask_dis, pwr_sw_a, pwr_sw_b, iso_en, burst_en}, 32'h2);
    chk("R11 reset req we", {30'd0, fz_req, buf_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NV; v++) run(VEC[v]);

    cur_lat = 8'd1; cur_stale = 1'b0; cur_base = 16'h0300;
    run_id++;
    @(negedge clk);
    start = 1'b1; start_addr = 16'h0300; byte_size = 16'd16; skip_pwr_sw = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R11 mid-run busy", {31'd0, busy}, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid-run reset busy", {31'd0, busy}, 0);
    chk("R11 mid-run reset power", {27'd0, wmask_dis, pwr_sw_a, pwr_sw_b, iso_en, burst_en}, 32'h2);
    chk("R11 mid-run reset req we", {30'd0, fz_req, buf_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(VEC[0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule